// File: doc/BRIEF.md
# Fractional-N Feedback Divider Controller

This block is the digital heart of a fractional-N synthesizer feedback path. It divides a high-rate input clock by an integer ratio. That ratio is redrawn once per output period from a base integer value plus a small signed correction. The correction comes from a third-order cascaded-accumulator noise shaper whose accumulators wrap at a programmable modulus. Over many output periods, the mean number of input clocks per output pulse equals `INT + FRAC/MOD`.

Software-facing registers and the loop analog are outside this block. A new triple of integer part, numerator and modulus is presented on the inputs and captured with a one-cycle load strobe. The new settings take effect together at the next output pulse, and the noise shaper starts from a cleared state at that point. When the numerator is zero, the shaper stays cleared and the block is a plain integer divider.

Top module: `fracn_div_ctrl`

## Requirements
- R1: While `rst_ni` is low, `pulse_o` is low. After reset, the block runs with integer part 32 and numerator 0, so successive pulses are spaced exactly 32 clocks apart.
- R2: The spacing between consecutive `pulse_o` pulses always lies in [INT−3, INT+4] for the active integer part INT.
- R3: Take any run of P consecutive output periods that starts at the pulse where a configuration takes effect, with total length T clocks. Then |T·MOD − P·(INT·MOD + FRAC)| ≤ 5·MOD. For P ≥ 5·MOD, this bounds the mean ratio to within 1/MOD of INT + FRAC/MOD.
- R4: With FRAC = 0, every output period is exactly INT clocks long.
- R5: `load_i`, high for one clock, captures `int_i`, `frac_i` and `mod_i`. The period in progress keeps the old settings. The first period that starts at the next pulse is exactly the new INT clocks long.
- R6: `pulse_o` is high for exactly one clock per output period.
- R7: INT is accepted over the range 31 to 511, and MOD over 2 to 4095 with FRAC in 0..MOD−1. This includes the extremes INT = 511 with a non-zero FRAC, and INT = 31 with FRAC = MOD−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | One-cycle strobe that captures a new configuration |
| int_i | input | 9 | Integer part of the division ratio (31..511) |
| frac_i | input | 12 | Fractional numerator (0..MOD−1) |
| mod_i | input | 12 | Fractional modulus (2..4095) |
| pulse_o | output | 1 | One-clock pulse per divider period |

## Verification
The bench measures the clock count of every output period. It checks each period against the allowed window. It sums long runs and checks the sums against the exact rational mean. A wrapping error in a modulus accumulator would show up as drift in that sum. An off-by-one when the counter reloads shifts every period by one clock, and the integer-mode and reset spacing checks catch it. The configuration boundary is also probed directly. A design that applies a load immediately, instead of at the next pulse, shortens or stretches the period in progress. A design that keeps stale shaper state produces a first new period that differs from INT. The corner settings are MOD = 2, INT = 511 with a non-zero numerator (ratio up to 515), INT = 31 with FRAC = MOD−1 (ratio down to 28), and a 4095 modulus.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  localparam int INT_W = 9;
  localparam int MOD_W = 12;
  localparam int RAT_W = INT_W + 1;  // INT + 4 may exceed INT range
  localparam int Y_W   = 4;          // shaper output -3..+4
  localparam int NST   = 3;          // shaper order
  typedef logic signed [Y_W-1:0] shp_t;
endpackage

// File: rtl/mod_acc.sv
module mod_acc #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         clr_i,
  input  logic [W-1:0] mod_i,
  input  logic [W-1:0] inc_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o
);
  logic [W-1:0] acc_q;
  logic [W:0]   raw;

  always_comb begin
    raw     = {1'b0, acc_q} + {1'b0, inc_i};
    carry_o = (raw >= {1'b0, mod_i});
    sum_o   = carry_o ? W'(raw - {1'b0, mod_i}) : raw[W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else if (en_i)  acc_q <= sum_o;
  end
endmodule

// File: rtl/shape_comb.sv
module shape_comb
  import fracn_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  input  logic c1_i,
  input  logic c2_i,
  input  logic c3_i,
  output shp_t y_o
);
  logic c2d_q, c3d_q, c3dd_q;

  function automatic shp_t b2s(input logic b);
    return shp_t'({3'b000, b});
  endfunction

  always_comb
    y_o = b2s(c1_i) + b2s(c2_i) - b2s(c2d_q)
        + b2s(c3_i) - (b2s(c3d_q) <<< 1) + b2s(c3dd_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c2d_q <= 1'b0; c3d_q <= 1'b0; c3dd_q <= 1'b0;
    end else if (clr_i) begin
      c2d_q <= 1'b0; c3d_q <= 1'b0; c3dd_q <= 1'b0;
    end else if (en_i) begin
      c2d_q <= c2_i; c3d_q <= c3_i; c3dd_q <= c3d_q;
    end
  end

  assert_shape_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (y_o >= -4'sd3) && (y_o <= 4'sd4));
endmodule

// File: rtl/div_counter.sv
module div_counter #(
  parameter int W       = 10,
  parameter int RST_RAT = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] ratio_i,
  output logic         tc_o
);
  logic [W-1:0] cnt_q;

  assign tc_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= W'(RST_RAT - 1);
    else if (tc_o) cnt_q <= ratio_i - W'(1);
    else           cnt_q <= cnt_q - W'(1);
  end

  assert_single_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |=> !tc_o);
  assert_ratio_min_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> ratio_i >= W'(2));
endmodule

// File: rtl/fracn_div_ctrl.sv
module fracn_div_ctrl
  import fracn_pkg::*;
#(
  parameter int RST_INT = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [INT_W-1:0] int_i,
  input  logic [MOD_W-1:0] frac_i,
  input  logic [MOD_W-1:0] mod_i,
  output logic             pulse_o
);
  logic [INT_W-1:0] int_q, sh_int_q;
  logic [MOD_W-1:0] frac_q, mod_q, sh_frac_q, sh_mod_q;
  logic             pend_q;
  logic             tc, apply, step, clr, frac_nz;
  logic [MOD_W-1:0] inc [NST+1];
  logic [NST-1:0]   carry;
  shp_t             y;
  logic signed [RAT_W:0] ratio_s;
  logic [RAT_W-1:0] ratio;

  assign frac_nz = (frac_q != '0);
  assign apply   = tc && pend_q;
  assign step    = tc && !apply && frac_nz;
  assign clr     = apply || (tc && !frac_nz);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_q     <= INT_W'(RST_INT);
      frac_q    <= '0;
      mod_q     <= MOD_W'(2);
      sh_int_q  <= INT_W'(RST_INT);
      sh_frac_q <= '0;
      sh_mod_q  <= MOD_W'(2);
      pend_q    <= 1'b0;
    end else begin
      if (load_i) begin
        sh_int_q  <= int_i;
        sh_frac_q <= frac_i;
        sh_mod_q  <= mod_i;
      end
      if (apply) begin
        int_q  <= sh_int_q;
        frac_q <= sh_frac_q;
        mod_q  <= sh_mod_q;
      end
      if (load_i)     pend_q <= 1'b1;
      else if (apply) pend_q <= 1'b0;
    end
  end

  // cascaded modulus accumulators, each fed by the previous stage's sum
  assign inc[0] = frac_q;
  for (genvar k = 0; k < NST; k++) begin : g_stage
    mod_acc #(.W(MOD_W)) u_acc (
      .clk_i, .rst_ni,
      .en_i   (step),
      .clr_i  (clr),
      .mod_i  (mod_q),
      .inc_i  (inc[k]),
      .sum_o  (inc[k+1]),
      .carry_o(carry[k])
    );
    assert_acc_below_mod_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      inc[k+1] < mod_q);
  end

  shape_comb u_shape (
    .clk_i, .rst_ni,
    .en_i (step),
    .clr_i(clr),
    .c1_i (carry[0]),
    .c2_i (carry[1]),
    .c3_i (carry[2]),
    .y_o  (y)
  );

  always_comb begin
    ratio_s = $signed({2'b00, int_q}) + {{(RAT_W+1-Y_W){y[Y_W-1]}}, y};
    ratio   = apply ? RAT_W'(sh_int_q) : ratio_s[RAT_W-1:0];
  end

  div_counter #(.W(RAT_W), .RST_RAT(RST_INT)) u_cnt (
    .clk_i, .rst_ni,
    .ratio_i(ratio),
    .tc_o   (tc)
  );

  assign pulse_o = tc;

  assert_ratio_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc && !apply) |-> (ratio >= RAT_W'(int_q) - RAT_W'(3)) &&
                       (ratio <= RAT_W'(int_q) + RAT_W'(4)));
  assert_integer_mode_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc && !apply && !frac_nz) |-> ratio == RAT_W'(int_q));
  assert_pending_kept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !tc) |=> pend_q);
endmodule

// File: tb/tb_fracn_div_ctrl.sv
module tb_fracn_div_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0;
  logic [8:0] int_v = 9'd32;
  logic [11:0] frac_v = '0, mod_v = 12'd2;
  logic       pulse;

  int    checks = 0, fails = 0;
  longint cyc = 0;
  bit    prev_p = 1'b0, dbl = 1'b0, done = 1'b0;

  fracn_div_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load),
    .int_i(int_v), .frac_i(frac_v), .mod_i(mod_v), .pulse_o(pulse)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !done) begin
      fails++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected<=190000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n && pulse && prev_p) dbl = 1'b1;
    prev_p = pulse;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse(output longint t);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (pulse) begin t = cyc; return; end
    end
    t = cyc;
    chk(1'b0, "R6 no pulse", 0, 1);
  endtask

  function automatic longint mean_err(longint t, longint p, longint iv, longint fv, longint mv);
    longint e;
    e = t * mv - p * (iv * mv + fv);
    return (e < 0) ? -e : e;
  endfunction

  task automatic run_cfg(input int iv, input int fv, input int mv, input int p,
                         input bit chk_old, input int old_int);
    longint a, b, c, prev, total, d;
    wait_pulse(a);
    @(negedge clk);
    int_v = 9'(iv); frac_v = 12'(fv); mod_v = 12'(mv); load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    int_v = '0; frac_v = '0; mod_v = 12'd2;  // must have no effect after capture
    wait_pulse(b);
    if (chk_old) chk(b - a == old_int, "R5 old period kept", b - a, old_int);
    prev = b; total = 0;
    for (int k = 0; k < p; k++) begin
      wait_pulse(c);
      d = c - prev; prev = c; total += d;
      if (k == 0) chk(d == iv, "R5 first new period", d, iv);
      chk(d >= iv - 3 && d <= iv + 4, "R2 period window", d, iv);
      if (fv == 0) chk(d == iv, "R4 integer mode", d, iv);
    end
    chk(mean_err(total, p, iv, fv, mv) <= 5 * mv, "R3 mean ratio",
        total * mv, longint'(p) * (iv * mv + fv));
  endtask

  initial begin
    longint t0, t1;
    void'($urandom(32'd20240611));
    repeat (4) begin
      @(negedge clk);
      chk(pulse == 1'b0, "R1 pulse low in reset", pulse, 0);
    end
    rst_n = 1'b1;
    wait_pulse(t0);
    for (int k = 0; k < 3; k++) begin
      wait_pulse(t1);
      chk(t1 - t0 == 32, "R1 reset spacing", t1 - t0, 32);
      t0 = t1;
    end
    // directed corners
    run_cfg(40, 0, 9, 10, 1'b1, 32);        // R4, R5 from reset config
    run_cfg(31, 1, 2, 12, 1'b1, 40);        // R7 MOD=2
    run_cfg(31, 6, 7, 42, 1'b0, 0);         // R7 INT=31, FRAC=MOD-1
    run_cfg(511, 0, 100, 4, 1'b0, 0);       // R7 INT=511 integer
    run_cfg(511, 2, 3, 18, 1'b1, 511);      // R7 INT=511 fractional
    run_cfg(40, 4094, 4095, 200, 1'b0, 0);  // R7 MOD=4095
    // constrained random
    for (int r = 0; r < 4; r++) begin
      int iv, mv, fv;
      iv = 31 + int'($urandom_range(29));
      mv = 2 + int'($urandom_range(58));
      fv = 1 + int'($urandom_range(mv - 2));
      run_cfg(iv, fv, mv, 6 * mv, 1'b0, 0);
    end
    chk(!dbl, "R6 single-cycle pulse", dbl, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule